// File: doc/BRIEF.md
# Receive FIFO with Invertible Interrupts

This block buffers characters coming from a serial receiver in a 128-deep, 8-bit FIFO. The receiver pushes characters. The host pops them and sees each popped byte on a registered read-data port. The current fill count is always visible.

The block raises two sticky interrupt flags, and a configuration input selects the polarity of each:
- The empty flag marks either the host draining the last character, or a character arriving into an empty FIFO.
- The trigger flag marks either the fill count rising to a threshold, or the fill count falling to it. The threshold is a 4-bit field multiplied by eight.

A third sticky flag records characters lost to a full FIFO. One clear strobe drops all three flags.

A software flush input holds the receive FIFO empty for as long as it stays high. It is also passed straight out to clear a companion transmit FIFO.

Top module: `rxFifoIrq`

## Requirements
- R1: The FIFO holds up to 128 characters. `fillCount` never exceeds 128. Characters leave in the order they were accepted.
- R2: A pop on a non-empty FIFO presents the oldest character on `popData` after the next clock edge and lowers `fillCount` by one. A pop on an empty FIFO leaves `popData` and `fillCount` unchanged.
- R3: A push into a full FIFO with no pop in the same cycle is dropped. `fillCount` stays at 128 and `overrunFlag` is set. A push with a pop in the same cycle on a full FIFO is accepted.
- R4: A push and a pop in the same cycle on a non-empty FIFO leave `fillCount` unchanged and set no interrupt flag.
- R5: With `emptyInvert` = 0, `emptyIrq` is set by the edge at which a pop takes `fillCount` from 1 to 0.
- R6: With `emptyInvert` = 1, `emptyIrq` is set by the edge at which a push takes `fillCount` from 0 to 1. The 1-to-0 transition does not set it.
- R7: With `trigInvert` = 0, `trigIrq` is set by the edge at which `fillCount` rises from below `trigLevel`×8 to `trigLevel`×8. A level of 0 never sets it. Falling counts do not set it.
- R8: With `trigInvert` = 1, `trigIrq` is set by the edge at which `fillCount` falls from above `trigLevel`×8 to `trigLevel`×8. Rising counts do not set it.
- R9: Each flag stays set until `irqClear` is high at a clock edge. If a new event occurs at that same edge, the flag stays set.
- R10: While `fifoClear` is high, `fillCount` goes to 0 at the next edge and stays there. Pushes and pops are ignored, and no flag is set. `txFifoClear` equals `fifoClear` in the same cycle, with no register.
- R11: Asynchronous active-low reset clears `fillCount`, `popData` and all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Receiver offers a character this cycle |
| pushData | input | 8 | Character from the receiver |
| popStrobe | input | 1 | Host takes one character |
| fifoClear | input | 1 | Software flush of both FIFOs, level sensitive |
| emptyInvert | input | 1 | 0: empty event on last read; 1: on first arrival |
| trigInvert | input | 1 | 0: trigger on rising fill; 1: on draining |
| trigLevel | input | 4 | Threshold in units of eight characters |
| irqClear | input | 1 | Clears all sticky flags |
| popData | output | 8 | Last character popped |
| fillCount | output | 8 | Characters currently stored |
| emptyIrq | output | 1 | Sticky empty-event flag |
| trigIrq | output | 1 | Sticky trigger-event flag |
| overrunFlag | output | 1 | Sticky lost-character flag |
| txFifoClear | output | 1 | Flush request for the transmit FIFO |

## Verification
Every registered result is due one edge after its stimulus: `fillCount`, `popData` and all three flags are updated by the same edge that accepts the push or pop. The one exception is `txFifoClear`, which is combinational and is due in the same cycle. The bench drives inputs at a falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Its model applies each requirement to the same single step, and its scoreboard compares the popped byte in that window. `txFifoClear` is sampled one nanosecond after `fifoClear` changes, before any rising edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic push;   // store pushData
    logic pop;    // advance read side, load popData
    logic flush;  // drop all contents
  } rxqStrobes_t;
endpackage

// File: rtl/rxqDatapath.sv
module rxqDatapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxqStrobes_t                strb,
  input  logic [DW-1:0]              pushData,
  output logic [DW-1:0]              popData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop) begin
        rdPtr   <= bump(rdPtr);
        popData <= mem[rdPtr];
      end
      if (strb.push && !strb.pop)      count <= count + 1'b1;
      else if (strb.pop && !strb.push) count <= count - 1'b1;
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> count == '0);
endmodule

// File: rtl/rxqControl.sv
module rxqControl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int TRIG_SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushValid,
  input  logic                       popStrobe,
  input  logic                       fifoClear,
  input  logic                       emptyInvert,
  input  logic                       trigInvert,
  input  logic [3:0]                 trigLevel,
  input  logic                       irqClear,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output rxqStrobes_t                strb,
  output logic                       emptyIrq,
  output logic                       trigIrq,
  output logic                       overrunFlag
);
  localparam int CW = $clog2(DEPTH+1);

  logic          isFull, isEmpty, popOk, pushOk;
  logic [CW-1:0] nextCount, thrLevel;
  logic          emptyEvt, trigEvt, overrunEvt;

  assign isFull   = (count == CW'(DEPTH));
  assign isEmpty  = (count == '0);
  assign thrLevel = CW'(trigLevel) << TRIG_SHIFT;

  assign popOk  = popStrobe && !isEmpty && !fifoClear;
  assign pushOk = pushValid && (!isFull || popOk) && !fifoClear;

  assign strb.push  = pushOk;
  assign strb.pop   = popOk;
  assign strb.flush = fifoClear;

  always_comb begin
    nextCount = count;
    if (pushOk && !popOk)      nextCount = count + 1'b1;
    else if (popOk && !pushOk) nextCount = count - 1'b1;
  end

  always_comb begin
    emptyEvt = 1'b0;
    trigEvt  = 1'b0;
    if (!fifoClear) begin
      emptyEvt = emptyInvert ? (isEmpty && nextCount == CW'(1))
                             : (count == CW'(1) && nextCount == '0);
      trigEvt  = trigInvert  ? (count > thrLevel && nextCount == thrLevel)
                             : (count < thrLevel && nextCount == thrLevel);
    end
    overrunEvt = pushValid && isFull && !popOk && !fifoClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyIrq    <= 1'b0;
      trigIrq     <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      emptyIrq    <= emptyEvt   || (emptyIrq    && !irqClear);
      trigIrq     <= trigEvt    || (trigIrq     && !irqClear);
      overrunFlag <= overrunEvt || (overrunFlag && !irqClear);
    end
  end

  // R9
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq && !irqClear |=> emptyIrq);
  // R9
  trig_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigIrq && !irqClear |=> trigIrq);
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull && pushValid && !popStrobe && !fifoClear |=> overrunFlag && count == CW'(DEPTH));
  // R4
  pair_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && popStrobe && !isEmpty && !fifoClear && !irqClear
    |=> $stable(count) && $stable(emptyIrq) && $stable(trigIrq));
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear && !irqClear |=> $stable(emptyIrq) && $stable(trigIrq) && $stable(overrunFlag));
endmodule

// File: rtl/rxFifoIrq.sv
module rxFifoIrq
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int DW         = 8,
  parameter int TRIG_SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushValid,
  input  logic [DW-1:0]              pushData,
  input  logic                       popStrobe,
  input  logic                       fifoClear,
  input  logic                       emptyInvert,
  input  logic                       trigInvert,
  input  logic [3:0]                 trigLevel,
  input  logic                       irqClear,
  output logic [DW-1:0]              popData,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       emptyIrq,
  output logic                       trigIrq,
  output logic                       overrunFlag,
  output logic                       txFifoClear
);
  rxqStrobes_t strb;

  assign txFifoClear = fifoClear;

  rxqControl #(.DEPTH(DEPTH), .TRIG_SHIFT(TRIG_SHIFT)) ctrl (
    .clk, .rstN, .pushValid, .popStrobe, .fifoClear, .emptyInvert,
    .trigInvert, .trigLevel, .irqClear, .count(fillCount), .strb,
    .emptyIrq, .trigIrq, .overrunFlag
  );

  rxqDatapath #(.DEPTH(DEPTH), .DW(DW)) dp (
    .clk, .rstN, .strb, .pushData, .popData, .count(fillCount)
  );

  // R2
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    popStrobe && !pushValid && fillCount == '0 |=> $stable(popData) && fillCount == '0);
endmodule

// File: tb/rxFifoIrq_test.sv
`timescale 1ns/1ps
module rxFifoIrq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 0, popStrobe = 0, fifoClear = 0;
  logic       emptyInvert = 0, trigInvert = 0, irqClear = 0;
  logic [7:0] pushData = '0;
  logic [3:0] trigLevel = '0;
  logic [7:0] popData, fillCount;
  logic       emptyIrq, trigIrq, overrunFlag, txFifoClear;

  int  checks = 0, fails = 0;
  bit  done = 0;
  logic [7:0] expQ[$];
  bit  mEmpty = 0, mTrig = 0, mOvr = 0;
  logic [7:0] mData = '0;

  always #2 clk = ~clk;

  rxFifoIrq uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver + monitor: one cycle, model updated from the requirements
  task automatic step(bit psh, logic [7:0] d, bit pop, bit clr = 0, bit fl = 0);
    int oldC, newC, thr;
    bit popOk, pushOk, isFull, isEmpty, eEv, tEv;
    @(negedge clk);
    pushValid = psh; pushData = d; popStrobe = pop; irqClear = clr; fifoClear = fl;
    oldC = expQ.size();
    isFull = (oldC == 128); isEmpty = (oldC == 0);
    popOk  = pop && !isEmpty && !fl;
    pushOk = psh && (!isFull || popOk) && !fl;
    if (popOk) mData = expQ.pop_front();
    if (pushOk) expQ.push_back(d);
    if (fl) expQ.delete();
    newC = expQ.size();
    thr = int'(trigLevel) * 8;
    eEv = !fl && (emptyInvert ? (oldC == 0 && newC == 1) : (oldC == 1 && newC == 0));
    tEv = !fl && (trigInvert ? (oldC > thr && newC == thr) : (oldC < thr && newC == thr));
    mEmpty = eEv || (mEmpty && !clr);
    mTrig  = tEv || (mTrig && !clr);
    mOvr   = (psh && isFull && !popOk && !fl) || (mOvr && !clr);
    @(posedge clk);
    @(negedge clk);
    pushValid = 0; popStrobe = 0; irqClear = 0;
    chk("R1", "fillCount", fillCount, newC);
    if (popOk) chk("R2", "popData", popData, mData);
    chk(emptyInvert ? "R6" : "R5", "emptyIrq", emptyIrq, mEmpty);
    chk(trigInvert ? "R8" : "R7", "trigIrq", trigIrq, mTrig);
    chk("R3", "overrunFlag", overrunFlag, mOvr);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #9;
    // R11 reset state
    chk("R11", "fillCount", fillCount, 0);
    chk("R11", "popData", popData, 0);
    chk("R11", "flags", {emptyIrq, trigIrq, overrunFlag}, 0);
    rstN = 1'b1;

    // R7 rising trigger at 8, R1 order, R5 empty on last read
    trigLevel = 4'd1;
    for (int i = 0; i < 10; i++) step(1, 8'(i * 7 + 3), 0);
    chk("R7", "trigIrq after fill to 10", trigIrq, 1);
    step(0, 0, 0, 1);
    chk("R9", "flags cleared", {emptyIrq, trigIrq}, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    chk("R7", "no trigger while draining", trigIrq, 0);
    chk("R5", "emptyIrq after last read", emptyIrq, 1);

    // R2 pop while empty keeps data
    step(0, 0, 1);
    chk("R2", "popData held on empty pop", popData, 8'(9 * 7 + 3));

    // R9 clear with no event, then event and clear together
    step(1, 8'h55, 0, 1);
    chk("R9", "emptyIrq cleared", emptyIrq, 0);
    step(0, 0, 1);
    emptyInvert = 1;
    step(0, 0, 0, 1);
    step(1, 8'h66, 0, 1);
    chk("R9", "event wins over clear", emptyIrq, 1);
    step(0, 0, 1, 1);
    chk("R6", "no empty event on drain", emptyIrq, 0);
    step(1, 8'h11, 0);
    chk("R6", "emptyIrq on first arrival", emptyIrq, 1);

    // R8 drain-down trigger, R4 simultaneous push/pop
    step(0, 0, 0, 1);
    trigInvert = 1;
    for (int i = 0; i < 11; i++) step(1, 8'(i + 40), 0);
    chk("R8", "no trigger while filling", trigIrq, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    chk("R8", "trigIrq at drain to 8", trigIrq, 1);
    step(0, 0, 0, 1);
    step(1, 8'hA5, 1);
    chk("R4", "count stable on push+pop", fillCount, 8);
    chk("R4", "no flag on push+pop", {emptyIrq, trigIrq}, 0);

    // R3 overrun at full
    trigInvert = 0; trigLevel = 4'd0; emptyInvert = 0;
    while (expQ.size() < 128) step(1, 8'(expQ.size() * 3), 0);
    step(1, 8'hEE, 0);
    chk("R3", "count held at full", fillCount, 128);
    chk("R3", "overrun set", overrunFlag, 1);
    step(1, 8'hC3, 1);
    chk("R3", "push+pop accepted at full", fillCount, 128);
    for (int i = 0; i < 128; i++) step(0, 0, 1);

    // R10 flush
    for (int i = 0; i < 5; i++) step(1, 8'(i), 0);
    @(negedge clk); fifoClear = 1; #1;
    chk("R10", "txFifoClear follows same cycle", txFifoClear, 1);
    step(1, 8'h77, 1, 0, 1);
    chk("R10", "count zero under flush", fillCount, 0);
    step(1, 8'h78, 0, 0, 1);
    chk("R10", "push ignored under flush", fillCount, 0);
    chk("R10", "no empty flag on flush", emptyIrq, mEmpty);
    @(negedge clk); fifoClear = 0; #1;
    chk("R10", "txFifoClear released", txFifoClear, 0);
    step(1, 8'h99, 0);
    step(0, 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule